// File: doc/BRIEF.md
# Serialized CSR Swap Unit

This block holds the control and status registers of a small in-order pipelined processor and carries out the only kind of instruction that touches them: an atomic swap. The swap reads the old value of one register, which goes back to the destination general register, and writes a new value taken from a general register. The unit also takes the update that hardware makes on interrupt entry, which changes several registers in the same cycle.

Swaps are serialized. When decode presents a swap, the unit raises `stall` to hold the front end. It waits until the pipeline reports that every older instruction has left. It then reads the register in one cycle and moves to a writeback-pending state, and the new value is written only on the writeback commit strobe. An exception flagged at writeback discards the write. An interrupt entry aborts any swap in flight, so the hardware update is never overwritten and the swap can run again after the handler returns. `stall` drops in the cycle after the swap finishes.

Four registers are implemented, each `DATA_W` bits wide: status at address 0, with the interrupt enable at bit `IE_BIT` (default 0); cause at address 1; exception PC at address 2; and a scratch register at address 3. Every other address reads as zero and ignores writes.

Top module: `csr_swap_unit`

## Requirements
- R1: A swap returns the register's value from before the swap on `rd_data`, with `rd_valid` high for exactly the cycle in which `wb_commit` is accepted. From the next cycle the register holds `dec_wdata`.
- R2: `stall` is high in the cycle in which a swap is presented on `dec_valid`. It stays high while the swap waits for `pipe_empty`, while it reads, and while it waits for writeback. It is low in the cycle after the swap commits or aborts, unless a new swap is being presented.
- R3: The register is not read before `pipe_empty` has been seen. An `irq_take` at any point between decode and commit aborts the swap, so no swap write lands after a hardware update.
- R4: A swap writes only when `wb_commit` is accepted. If `wb_cancel` is high in that cycle, the write and the `rd_valid` pulse are discarded, and `stall` drops in the next cycle.
- R5: On `irq_take`, address 2 loads `irq_pc`, address 1 loads `irq_cause`, and bit `IE_BIT` of address 0 is cleared. Every other bit of address 0 keeps its value, and so does address 3.
- R6: When `irq_take` and `wb_commit` fall in the same cycle, the interrupt update wins. The swap writes nothing and `rd_valid` stays low.
- R7: A swap to an address of 4 or above returns zero and leaves all registers unchanged.
- R8: A synchronous active-high `rst` clears all four registers to zero and abandons any swap in progress, so `stall` is low after reset.
- R9: `dec_valid` is ignored while a swap is in progress. A second request presented then changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A swap is presented at decode |
| dec_addr | input | ADDR_W | Register address of the swap |
| dec_wdata | input | DATA_W | New value from the general register |
| pipe_empty | input | 1 | All older instructions have left the pipeline |
| wb_commit | input | 1 | Writeback commit strobe for the swap |
| wb_cancel | input | 1 | Exception flagged for the swap at writeback |
| irq_take | input | 1 | Interrupt entry this cycle |
| irq_cause | input | DATA_W | Cause value for interrupt entry |
| irq_pc | input | DATA_W | PC of the oldest uncommitted instruction |
| stall | output | 1 | Hold the front end |
| rd_valid | output | 1 | Old value is being returned to the register writeback path |
| rd_data | output | DATA_W | Old register value read by the swap |

## Verification
The hardest cases to reach are an interrupt that lands exactly on the writeback commit cycle and one that lands in the single read cycle. Reaching either from the ports needs `irq_take` placed against the swap's internal phase. The bench drives each swap one phase at a time with a task that counts edges from decode, so it can raise the interrupt in the drain wait, in the read cycle or on the commit cycle. A follow-up swap to the same address then shows whether any stale write got through.

// File: rtl/csr_swap_pkg.sv
package csr_swap_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DRAIN = 2'd1,
    SW_READ  = 2'd2,
    SW_WB    = 2'd3
  } swap_st_e;

  localparam int unsigned CSR_STATUS  = 0;
  localparam int unsigned CSR_CAUSE   = 1;
  localparam int unsigned CSR_EPC     = 2;
  localparam int unsigned CSR_SCRATCH = 3;
  localparam int unsigned CSR_COUNT   = 4;

endpackage

// File: rtl/csr_swap_ctrl.sv
module csr_swap_ctrl
  import csr_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [DATA_W-1:0] dec_wdata,
  input  logic              pipe_empty,
  input  logic              wb_commit,
  input  logic              wb_cancel,
  input  logic              irq_take,
  output swap_st_e          st,
  output logic              stall,
  output logic              do_read,
  output logic              do_commit,
  output logic              do_abort,
  output logic [ADDR_W-1:0] sw_addr,
  output logic [DATA_W-1:0] sw_data
);

  swap_st_e st_q, st_d;
  logic     accept;

  assign accept = (st_q == SW_IDLE) && dec_valid && !irq_take;

  always_comb begin
    do_read   = (st_q == SW_READ);
    do_commit = (st_q == SW_WB) && wb_commit && !wb_cancel && !irq_take;
    do_abort  = (st_q != SW_IDLE) &&
                (irq_take || ((st_q == SW_WB) && wb_commit && wb_cancel));
    stall     = (st_q != SW_IDLE) || accept;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SW_IDLE:  if (accept) st_d = SW_DRAIN;
      SW_DRAIN: if (do_abort) st_d = SW_IDLE;
                else if (pipe_empty) st_d = SW_READ;
      SW_READ:  st_d = do_abort ? SW_IDLE : SW_WB;
      SW_WB:    if (do_abort || do_commit) st_d = SW_IDLE;
      default:  st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SW_IDLE;
      sw_addr <= '0;
      sw_data <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        sw_addr <= dec_addr;
        sw_data <= dec_wdata;
      end
    end
  end

  assign st = st_q;

endmodule

// File: rtl/csr_swap_regs.sv
module csr_swap_regs
  import csr_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IE_BIT = 0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               wr_en,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               irq_take,
  input  logic [DATA_W-1:0]                  irq_cause,
  input  logic [DATA_W-1:0]                  irq_pc,
  output logic [DATA_W-1:0]                  rd_value,
  output logic                               addr_hit,
  output logic [CSR_COUNT-1:0][DATA_W-1:0]   csr_q
);

  localparam int unsigned IDX_W = $clog2(CSR_COUNT);

  logic [IDX_W-1:0] idx;

  // Next value of register i on interrupt entry.
  function automatic logic [DATA_W-1:0] irq_next(int unsigned i,
                                                 logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] cause,
                                                 logic [DATA_W-1:0] pc);
    logic [DATA_W-1:0] v;
    v = cur;
    if (i == CSR_CAUSE)  v = cause;
    if (i == CSR_EPC)    v = pc;
    if (i == CSR_STATUS) v[IE_BIT] = 1'b0;
    return v;
  endfunction

  assign addr_hit = (addr < ADDR_W'(CSR_COUNT));
  assign idx      = addr[IDX_W-1:0];
  assign rd_value = addr_hit ? csr_q[idx] : '0;

  always_ff @(posedge clk) begin
    for (int unsigned i = 0; i < CSR_COUNT; i++) begin
      if (rst)
        csr_q[i] <= '0;
      else if (irq_take)
        csr_q[i] <= irq_next(i, csr_q[i], irq_cause, irq_pc);
      else if (wr_en && addr_hit && (idx == IDX_W'(i)))
        csr_q[i] <= wr_data;
    end
  end

endmodule

// File: rtl/csr_swap_unit.sv
module csr_swap_unit
  import csr_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [DATA_W-1:0] dec_wdata,
  input  logic              pipe_empty,
  input  logic              wb_commit,
  input  logic              wb_cancel,
  input  logic              irq_take,
  input  logic [DATA_W-1:0] irq_cause,
  input  logic [DATA_W-1:0] irq_pc,
  output logic              stall,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  swap_st_e                           st;
  logic                               swap_read;
  logic                               swap_commit;
  logic                               swap_abort;
  logic                               addr_hit;
  logic [ADDR_W-1:0]                  sw_addr;
  logic [DATA_W-1:0]                  sw_data;
  logic [DATA_W-1:0]                  rd_value;
  logic [DATA_W-1:0]                  old_q;
  logic [CSR_COUNT-1:0][DATA_W-1:0]   csr_q;

  csr_swap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_addr   (dec_addr),
    .dec_wdata  (dec_wdata),
    .pipe_empty (pipe_empty),
    .wb_commit  (wb_commit),
    .wb_cancel  (wb_cancel),
    .irq_take   (irq_take),
    .st         (st),
    .stall      (stall),
    .do_read    (swap_read),
    .do_commit  (swap_commit),
    .do_abort   (swap_abort),
    .sw_addr    (sw_addr),
    .sw_data    (sw_data)
  );

  csr_swap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IE_BIT(IE_BIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (sw_addr),
    .wr_en     (swap_commit),
    .wr_data   (sw_data),
    .irq_take  (irq_take),
    .irq_cause (irq_cause),
    .irq_pc    (irq_pc),
    .rd_value  (rd_value),
    .addr_hit  (addr_hit),
    .csr_q     (csr_q)
  );

  // Old value is captured in the read cycle and held until writeback.
  always_ff @(posedge clk) begin
    if (rst)            old_q <= '0;
    else if (swap_read) old_q <= rd_value;
  end

  assign rd_valid = swap_commit;
  assign rd_data  = old_q;

endmodule

// File: rtl/csr_swap_unit_chk.sv
module csr_swap_unit_chk
  import csr_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IE_BIT = 0
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             irq_take,
  input logic                             wb_commit,
  input logic                             wb_cancel,
  input logic [DATA_W-1:0]                irq_cause,
  input logic [DATA_W-1:0]                irq_pc,
  input logic                             stall,
  input logic                             rd_valid,
  input swap_st_e                         st,
  input logic                             swap_commit,
  input logic                             addr_hit,
  input logic [CSR_COUNT-1:0][DATA_W-1:0] csr_q
);

  p_stall_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (st != SW_IDLE) |-> stall);

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (st == SW_IDLE));

  p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((st == SW_READ) && !irq_take) |=> (csr_q == $past(csr_q)));

  p_wb_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((st == SW_WB) && !rd_valid && !irq_take) |=> (csr_q == $past(csr_q)));

  p_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == SW_WB) && wb_commit && wb_cancel && !irq_take)
      |=> ((csr_q == $past(csr_q)) && (st == SW_IDLE)));

  p_irq_update_r5: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> ((csr_q[CSR_EPC] == $past(irq_pc)) &&
                  (csr_q[CSR_CAUSE] == $past(irq_cause)) &&
                  !csr_q[CSR_STATUS][IE_BIT]));

  p_irq_wins_r6: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !rd_valid);

  p_unimpl_r7: assert property (@(posedge clk) disable iff (rst)
    (swap_commit && !addr_hit) |=> (csr_q == $past(csr_q)));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> ((csr_q == '0) && (st == SW_IDLE)));

endmodule

bind csr_swap_unit csr_swap_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IE_BIT(IE_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_take    (irq_take),
  .wb_commit   (wb_commit),
  .wb_cancel   (wb_cancel),
  .irq_cause   (irq_cause),
  .irq_pc      (irq_pc),
  .stall       (stall),
  .rd_valid    (rd_valid),
  .st          (st),
  .swap_commit (swap_commit),
  .addr_hit    (addr_hit),
  .csr_q       (csr_q)
);

// File: tb/csr_swap_unit_test.sv
module csr_swap_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_valid = 1'b0;
  logic [3:0]  dec_addr = '0;
  logic [31:0] dec_wdata = '0;
  logic        pipe_empty = 1'b0;
  logic        wb_commit = 1'b0;
  logic        wb_cancel = 1'b0;
  logic        irq_take = 1'b0;
  logic [31:0] irq_cause = '0;
  logic [31:0] irq_pc = '0;
  logic        stall;
  logic        rd_valid;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_csr [4];
  logic        exp_stall = 1'b0;
  logic        exp_rdv   = 1'b0;
  logic [31:0] exp_rdata = '0;

  always #5 clk = ~clk;

  csr_swap_unit uut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_addr(dec_addr),
    .dec_wdata(dec_wdata), .pipe_empty(pipe_empty), .wb_commit(wb_commit),
    .wb_cancel(wb_cancel), .irq_take(irq_take), .irq_cause(irq_cause),
    .irq_pc(irq_pc), .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference model.
  always @(negedge clk) begin
    chk(stall === exp_stall, "R2 stall", 32'(stall), 32'(exp_stall));
    chk(rd_valid === exp_rdv, "R1 rd_valid", 32'(rd_valid), 32'(exp_rdv));
    if (exp_rdv) chk(rd_data === exp_rdata, "R1 rd_data", rd_data, exp_rdata);
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    return (a < 4) ? m_csr[a[1:0]] : 32'h0;
  endfunction

  task automatic model_irq(input logic [31:0] c, input logic [31:0] p);
    m_csr[1] = c;
    m_csr[2] = p;
    m_csr[0][0] = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_irq(input logic [31:0] c, input logic [31:0] p);
    irq_take = 1'b1; irq_cause = c; irq_pc = p;
    step();
    irq_take = 1'b0;
    model_irq(c, p);
  endtask

  // mode: 0 commit, 1 cancel, 2 irq on commit, 3 irq in drain,
  //       4 reset in writeback, 5 irq in read cycle
  task automatic swap(input logic [3:0] a, input logic [31:0] d, input int drain,
                      input int mode, input bit noise, input string req);
    logic [31:0] old;
    old = model_rd(a);
    dec_valid = 1'b1; dec_addr = a; dec_wdata = d; exp_stall = 1'b1;
    step();
    dec_valid = 1'b0;
    for (int i = 0; i < drain; i++) begin
      if (noise) begin dec_valid = 1'b1; dec_addr = 4'd3; dec_wdata = 32'hffff_ffff; end
      step();
    end
    dec_valid = 1'b0;
    if (mode == 3) begin
      do_irq(32'h33, 32'h300);
      exp_stall = 1'b0;
      return;
    end
    pipe_empty = 1'b1;
    step();                       // now in read cycle
    pipe_empty = 1'b0;
    if (mode == 5) begin
      do_irq(32'h55, 32'h500);
      exp_stall = 1'b0;
      return;
    end
    step();                       // now waiting for writeback
    chk(rd_data === old, {req, " old value held"}, rd_data, old);
    step();                       // one extra writeback wait cycle
    case (mode)
      0: begin
        wb_commit = 1'b1; exp_rdv = 1'b1; exp_rdata = old;
        step();
        wb_commit = 1'b0; exp_rdv = 1'b0; exp_stall = 1'b0;
        if (a < 4) m_csr[a[1:0]] = d;
      end
      1: begin
        wb_commit = 1'b1; wb_cancel = 1'b1;
        step();
        wb_commit = 1'b0; wb_cancel = 1'b0; exp_stall = 1'b0;
      end
      2: begin
        wb_commit = 1'b1;
        do_irq(32'h22, 32'h200);
        wb_commit = 1'b0; exp_stall = 1'b0;
      end
      default: begin
        rst = 1'b1;
        step();
        rst = 1'b0; exp_stall = 1'b0;
        for (int k = 0; k < 4; k++) m_csr[k] = '0;
      end
    endcase
  endtask

  // Read a register back through a committed swap that restores its value.
  task automatic peek(input logic [3:0] a, input string req);
    logic [31:0] v;
    v = model_rd(a);
    swap(a, v, 1, 0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_csr[k] = '0;
    repeat (3) step();
    rst = 1'b0;
    chk(stall === 1'b0, "R8 stall after reset", 32'(stall), 0);

    // R8 reset state: each register reads zero, then gets a value (R1)
    swap(4'd0, 32'h0000_00f1, 2, 0, 1'b0, "R8 status");
    swap(4'd1, 32'h1111_0001, 0, 0, 1'b0, "R8 cause");
    swap(4'd2, 32'h2222_0002, 3, 0, 1'b0, "R8 epc");
    swap(4'd3, 32'h3333_0003, 1, 0, 1'b0, "R8 scratch");
    swap(4'd3, 32'hcafe_f00d, 4, 0, 1'b0, "R1 swap scratch");

    // R4 cancel at writeback
    swap(4'd3, 32'hdead_0001, 1, 1, 1'b0, "R4 cancel");
    peek(4'd3, "R4 unchanged");

    // R5 interrupt entry while idle
    do_irq(32'h8000_0007, 32'h0000_1234);
    peek(4'd1, "R5 cause");
    peek(4'd2, "R5 epc");
    peek(4'd0, "R5 status ie clear");
    peek(4'd3, "R5 scratch kept");

    // R6 interrupt on the commit cycle
    swap(4'd3, 32'hbad0_0006, 2, 2, 1'b0, "R6 irq at commit");
    peek(4'd3, "R6 scratch unchanged");
    peek(4'd2, "R6 epc");

    // R3 interrupt during drain and during the read cycle
    swap(4'd2, 32'hbad0_0003, 2, 3, 1'b0, "R3 irq in drain");
    peek(4'd2, "R3 epc from irq");
    swap(4'd1, 32'hbad0_0005, 1, 5, 1'b0, "R3 irq in read");
    peek(4'd1, "R3 cause from irq");

    // R7 unimplemented address
    swap(4'd9, 32'h9999_9999, 1, 0, 1'b0, "R7 unimpl first");
    swap(4'd9, 32'h7777_7777, 1, 0, 1'b0, "R7 unimpl reads zero");
    peek(4'd3, "R7 scratch unchanged");

    // R9 requests ignored while busy
    swap(4'd0, 32'h0000_0001, 3, 0, 1'b1, "R9 noisy drain");
    peek(4'd3, "R9 scratch untouched");
    peek(4'd0, "R9 status written");

    // R8 reset in the middle of a swap
    swap(4'd3, 32'h1357_9bdf, 1, 4, 1'b0, "R8 reset in wb");
    peek(4'd3, "R8 scratch zero");
    peek(4'd0, "R8 status zero");
    peek(4'd2, "R8 epc zero");

    repeat (2) step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule